// File: doc/BRIEF.md
# Programming-Port Command Decoder with Unlock

This block sits behind the serial physical layer of a device programming port and interprets the byte stream it delivers. Each byte arrives on a valid/ready input. In the idle state a byte is taken as a command. A command can read one of sixteen small control/status registers out to the transmit side, write the byte that follows into one of them, or collect an eight-byte unlock key that gates access to non-volatile memory programming.

Register 0 is the status register. It holds a sticky error flag and the memory-enable flag. A correct key sets the enable flag after a fixed latency, and the host learns that enabling has finished by polling the flag. A store command can clear the flag again, but only the key can set it. The enable flag is also driven out of the block to the memory controller.

Top module: `progport_cmd_dec`

## Requirements
- R1: After reset, rx_ready is 1, tx_valid is 0, nvm_en is 0, and every register (status included) reads back as 0x00.
- R2: A command byte 1000_aaaa copies register aaaa onto tx_data and raises tx_valid on the next cycle. tx_valid and tx_data then hold steady until a cycle with tx_ready high, and rx_ready stays 0 for that whole time.
- R3: A command byte 1100_aaaa makes the next accepted byte the new content of register aaaa. For addresses 1 to 15 the full byte is stored and reads back unchanged.
- R4: The command byte 0xE0 is followed by exactly eight key bytes, taken least-significant byte first. The accepted key 0x1289AB45CDD888FF is therefore sent as FF, 88, D8, CD, 45, AB, 89, 12.
- R5: With a correct key, nvm_en and status bit 1 become 1 exactly EN_DELAY clock edges (default 4) after the edge that accepts the eighth key byte, and not before.
- R6: With a wrong key, nvm_en stays 0, status bit 0 (error) is set, and the decoder returns to waiting for a command.
- R7: A store to address 0 with bit 1 equal to 0 clears nvm_en. A store with bit 1 equal to 1 leaves nvm_en unchanged.
- R8: A command byte matching no opcode is otherwise ignored but sets status bit 0. That bit stays 1 until a store to address 0 with bit 0 equal to 0, and writing 1 to it has no effect.
- R9: A store that clears bit 1 while an enable is pending cancels it, including when the store lands on the very edge the enable would have taken effect. nvm_en then stays 0.
- R10: Status bits 7 to 2 always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Incoming byte is valid |
| rx_data | input | 8 | Incoming byte from the physical layer |
| rx_ready | output | 1 | Decoder can accept a byte |
| tx_valid | output | 1 | Loaded register byte is available |
| tx_data | output | 8 | Loaded register byte |
| tx_ready | input | 1 | Physical layer takes the loaded byte |
| nvm_en | output | 1 | Non-volatile memory programming enabled |

## Verification
The delayed enable set and a clearing store can meet on the same edge. To provoke this, the bench times a store of 0x00 to the status register so that its data byte is accepted exactly EN_DELAY edges after the last key byte. It then also issues one such store earlier, while the enable is still pending. In both cases a cycle-accurate behavioural model in the bench predicts that nvm_en stays 0. The bench compares nvm_en and the transmit outputs against that model on every clock and confirms the result with status read-backs.

// File: rtl/pp_pkg.sv
// Shared opcodes, status bit positions and decoder states for the
// programming-port command decoder. Assumes byte-wide commands.
package pp_pkg;
    localparam int          BYTE_W      = 8;
    localparam logic [3:0]  OPC_LOAD    = 4'b1000;
    localparam logic [3:0]  OPC_STORE   = 4'b1100;
    localparam logic [7:0]  OPC_KEY     = 8'hE0;
    localparam int          STAT_ERR    = 0;
    localparam int          STAT_EN     = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STORE,
        ST_KEY,
        ST_TXWAIT
    } seq_state_t;
endpackage

// File: rtl/pp_seq.sv
// Command sequencer: takes bytes from the receive handshake, decodes
// opcodes, issues register reads and writes, and feeds key bytes to the
// key unit. Assumes one byte per cycle at most and a combinational read port.
module pp_seq
    import pp_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int KEY_BYTES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [BYTE_W-1:0]   rx_data,
    output logic                rx_ready,
    output logic                tx_valid,
    output logic [BYTE_W-1:0]   tx_data,
    input  logic                tx_ready,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                key_vld,
    output logic [BYTE_W-1:0]   key_byte,
    output logic                key_last,
    output logic                bad_op
);
    localparam int KW = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;

    seq_state_t          state;
    logic [ADDR_W-1:0]   st_addr;
    logic [KW-1:0]       kcnt;
    logic                accept;
    logic                is_load, is_store, is_key;

    // Decode of the current byte and the handshake strobes.
    always_comb begin
        rx_ready = (state != ST_TXWAIT);
        accept   = rx_valid && rx_ready;
        is_load  = (rx_data[7:4] == OPC_LOAD);
        is_store = (rx_data[7:4] == OPC_STORE);
        is_key   = (rx_data == OPC_KEY);
        rd_addr  = rx_data[ADDR_W-1:0];
        wr_en    = accept && (state == ST_STORE);
        wr_addr  = st_addr;
        wr_data  = rx_data;
        key_vld  = accept && (state == ST_KEY);
        key_byte = rx_data;
        key_last = key_vld && (kcnt == KW'(KEY_BYTES - 1));
        bad_op   = accept && (state == ST_IDLE) && !is_load && !is_store && !is_key;
    end

    // Sequencer state, latched store address, key byte count and transmit holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            st_addr  <= '0;
            kcnt     <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    if (is_load) begin
                        tx_data  <= rd_data;
                        tx_valid <= 1'b1;
                        state    <= ST_TXWAIT;
                    end else if (is_store) begin
                        st_addr  <= rx_data[ADDR_W-1:0];
                        state    <= ST_STORE;
                    end else if (is_key) begin
                        kcnt     <= '0;
                        state    <= ST_KEY;
                    end
                end
                ST_STORE: if (accept) state <= ST_IDLE;
                ST_KEY: if (accept) begin
                    kcnt <= kcnt + 1'b1;
                    if (key_last) state <= ST_IDLE;
                end
                ST_TXWAIT: if (tx_ready) begin
                    tx_valid <= 1'b0;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pp_key_unit.sv
// Key unit: assembles key bytes least-significant first, compares after the
// last byte, and times the enable latency. Assumes EN_DELAY >= 1, KEY_BYTES >= 2.
module pp_key_unit
    import pp_pkg::*;
#(
    parameter int                      KEY_BYTES  = 8,
    parameter logic [KEY_BYTES*8-1:0]  UNLOCK_KEY = 64'h1289AB45CDD888FF,
    parameter int                      EN_DELAY   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                key_vld,
    input  logic [BYTE_W-1:0]   key_byte,
    input  logic                key_last,
    input  logic                cancel,
    output logic                set_req,
    output logic                mismatch
);
    localparam int KBITS = KEY_BYTES * BYTE_W;
    localparam int CW    = $clog2(EN_DELAY + 1);

    logic [KBITS-1:0] shreg;
    logic [KBITS-1:0] assembled;
    logic [CW-1:0]    dly;
    logic             match_now;

    // Key as it stands including the byte on the input this cycle.
    always_comb begin
        assembled = {key_byte, shreg[KBITS-1:BYTE_W]};
        match_now = key_last && (assembled == UNLOCK_KEY);
        mismatch  = key_last && (assembled != UNLOCK_KEY);
        set_req   = (dly == CW'(1));
    end

    // Key shift register, newest byte entering at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)       shreg <= '0;
        else if (key_vld) shreg <= assembled;
    end

    // Enable latency counter; a clearing store cancels a pending enable.
    always_ff @(posedge clk) begin
        if (!rst_n)           dly <= '0;
        else if (cancel)      dly <= '0;
        else if (match_now)   dly <= CW'(EN_DELAY);
        else if (dly != '0)   dly <= dly - 1'b1;
    end
endmodule

// File: rtl/pp_csr_bank.sv
// Control/status register space: status at address 0 (error and enable
// flags), plain byte registers elsewhere. Assumes one write per cycle.
module pp_csr_bank
    import pp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                set_req,
    input  logic                err_set,
    output logic                clr_en,
    output logic                nvm_en,
    output logic                err_flag
);
    localparam int NREG = 1 << ADDR_W;

    logic [BYTE_W-1:0] file [NREG];
    logic              stat_wr;
    logic [BYTE_W-1:0] stat_val;

    // Status write decode and status byte image.
    always_comb begin
        stat_wr            = wr_en && (wr_addr == '0);
        clr_en             = stat_wr && !wr_data[STAT_EN];
        stat_val           = '0;
        stat_val[STAT_EN]  = nvm_en;
        stat_val[STAT_ERR] = err_flag;
    end

    // Enable flag: a clearing store wins over a pending set.
    always_ff @(posedge clk) begin
        if (!rst_n)       nvm_en <= 1'b0;
        else if (clr_en)  nvm_en <= 1'b0;
        else if (set_req) nvm_en <= 1'b1;
    end

    // Sticky error flag, cleared only by writing zero to its bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  err_flag <= 1'b0;
        else if (err_set)                            err_flag <= 1'b1;
        else if (stat_wr && !wr_data[STAT_ERR])      err_flag <= 1'b0;
    end

    assign file[0] = stat_val;

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        logic [BYTE_W-1:0] r;
        // Plain read/write byte register.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   r <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))    r <= wr_data;
        end
        assign file[g] = r;
    end

    assign rd_data = file[rd_addr];
endmodule

// File: rtl/progport_cmd_dec.sv
// Top of the programming-port command decoder: joins the sequencer, key
// unit and register bank. Assumes the physical layer delivers whole bytes.
module progport_cmd_dec
    import pp_pkg::*;
#(
    parameter int                      ADDR_W     = 4,
    parameter int                      KEY_BYTES  = 8,
    parameter logic [KEY_BYTES*8-1:0]  UNLOCK_KEY = 64'h1289AB45CDD888FF,
    parameter int                      EN_DELAY   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        nvm_en
);
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [BYTE_W-1:0] rd_data, wr_data, key_byte;
    logic              wr_en, key_vld, key_last, bad_op;
    logic              set_req, mismatch, clr_en, err_flag, err_set;

    assign err_set = bad_op | mismatch;

    pp_seq #(.ADDR_W(ADDR_W), .KEY_BYTES(KEY_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .key_vld(key_vld), .key_byte(key_byte), .key_last(key_last),
        .bad_op(bad_op)
    );

    pp_key_unit #(.KEY_BYTES(KEY_BYTES), .UNLOCK_KEY(UNLOCK_KEY), .EN_DELAY(EN_DELAY)) u_key (
        .clk(clk), .rst_n(rst_n),
        .key_vld(key_vld), .key_byte(key_byte), .key_last(key_last),
        .cancel(clr_en), .set_req(set_req), .mismatch(mismatch)
    );

    pp_csr_bank #(.ADDR_W(ADDR_W)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .set_req(set_req), .err_set(err_set), .clr_en(clr_en),
        .nvm_en(nvm_en), .err_flag(err_flag)
    );
endmodule

// File: rtl/pp_chk.sv
// Property checker for the command decoder, attached by bind. Observes the
// handshake ports and the register-bank inputs and flags.
module pp_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              nvm_en,
    input logic              err_flag,
    input logic              set_req,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));  // R2
    AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);  // R2
    AST_EN_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nvm_en) |-> $past(set_req));  // R5
    AST_EN_FALL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nvm_en) |-> $past(wr_en && (wr_addr == '0) && !wr_data[1]));  // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> $past(wr_en && (wr_addr == '0) && !wr_data[0]));  // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == '0) && !wr_data[1]) |=> !nvm_en);  // R9
endmodule

bind progport_cmd_dec pp_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .nvm_en(nvm_en),
    .err_flag(err_flag), .set_req(set_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/progport_cmd_dec_tb.sv
module progport_cmd_dec_tb;
    localparam int          DLY  = 4;
    localparam logic [63:0] GOOD = 64'h1289AB45CDD888FF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_ready = 1'b0;
    logic       rx_ready, tx_valid, nvm_en;
    logic [7:0] tx_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    progport_cmd_dec u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .nvm_en(nvm_en)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    int       m_state;            // 0 idle, 1 store data, 2 key, 3 tx wait
    logic [7:0] m_regs [16];
    bit       m_en, m_err, m_txv;
    logic [7:0] m_tx;
    int       m_pend, m_addr;
    logic [7:0] m_keyq [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_en = 0; m_err = 0; m_txv = 0; m_tx = 0;
            m_pend = 0; m_addr = 0; m_keyq.delete();
            foreach (m_regs[i]) m_regs[i] = 8'h00;
        end else begin
            bit acc, clr, old_en, old_err;
            old_en = m_en; old_err = m_err;
            acc = rx_valid && (m_state != 3);
            clr = acc && (m_state == 1) && (m_addr == 0) && !rx_data[1];
            if (clr) begin m_en = 0; m_pend = 0; end
            else if (m_pend == 1) begin m_en = 1; m_pend = 0; end
            else if (m_pend > 0) m_pend--;
            case (m_state)
                0: if (acc) begin
                    if (rx_data[7:4] == 4'h8) begin
                        m_tx = (rx_data[3:0] == 0) ? {6'b0, old_en, old_err} : m_regs[rx_data[3:0]];
                        m_txv = 1; m_state = 3;
                    end else if (rx_data[7:4] == 4'hC) begin
                        m_addr = int'(rx_data[3:0]); m_state = 1;
                    end else if (rx_data == 8'hE0) begin
                        m_keyq.delete(); m_state = 2;
                    end else m_err = 1;
                end
                1: if (acc) begin
                    if (m_addr == 0) begin if (!rx_data[0]) m_err = 0; end
                    else m_regs[m_addr] = rx_data;
                    m_state = 0;
                end
                2: if (acc) begin
                    m_keyq.push_back(rx_data);
                    if (m_keyq.size() == 8) begin
                        logic [63:0] k;
                        k = 0;
                        for (int i = 0; i < 8; i++) k[8*i +: 8] = m_keyq[i];
                        if (k == GOOD) m_pend = DLY; else m_err = 1;
                        m_state = 0;
                    end
                end
                3: if (tx_ready) begin m_txv = 0; m_state = 0; end
                default: m_state = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 rx_ready", {7'b0, rx_ready}, {7'b0, (m_state != 3)});
            chk("R2 tx_valid", {7'b0, tx_valid}, {7'b0, m_txv});
            if (m_txv) chk("R2 tx_data", tx_data, m_tx);
            chk("R5 nvm_en", {7'b0, nvm_en}, {7'b0, m_en});
        end
    end

    task automatic send(input logic [7:0] b);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rd(input int a, input int hold, output logic [7:0] v);
        send(8'h80 | 8'(a));
        repeat (hold) @(negedge clk);
        v = tx_data;
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        send(8'hC0 | 8'(a));
        send(d);
    endtask

    task automatic key(input logic [63:0] k);
        send(8'hE0);
        for (int i = 0; i < 8; i++) send(k[8*i +: 8]);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_ready", {7'b0, rx_ready}, 8'h01);
        chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        chk("R1 nvm_en", {7'b0, nvm_en}, 8'h00);
        rd(0, 0, v); chk("R1 status", v, 8'h00);
        rd(5, 0, v); chk("R1 reg5", v, 8'h00);
        // R3 stores, R2 held load
        wr(3, 8'hA5); wr(15, 8'h3C); wr(1, 8'hFF);
        rd(3, 3, v); chk("R3 reg3", v, 8'hA5);
        rd(15, 0, v); chk("R3 reg15", v, 8'h3C);
        rx_valid = 1'b1; rx_data = 8'hC2;
        rd(1, 4, v); chk("R2 held load", v, 8'hFF);
        rx_valid = 1'b0;
        @(negedge clk);
        // R8 bad opcode, sticky error
        send(8'h55);
        rd(0, 0, v); chk("R8 err set", v, 8'h01);
        wr(0, 8'h01);
        rd(0, 0, v); chk("R8 write one keeps", v, 8'h01);
        wr(0, 8'h00);
        rd(0, 0, v); chk("R8 cleared", v, 8'h00);
        // R6 wrong key
        key(GOOD ^ 64'h0000_0100_0000_0000);
        repeat (DLY + 4) @(negedge clk);
        chk("R6 en stays 0", {7'b0, nvm_en}, 8'h00);
        rd(0, 0, v); chk("R6 err", v, 8'h01);
        wr(0, 8'h00);
        // R4/R5 correct key, exact latency
        key(GOOD);
        for (int i = 1; i < DLY; i++) begin
            @(negedge clk); chk("R5 not early", {7'b0, nvm_en}, 8'h00);
        end
        @(negedge clk); chk("R4 R5 enabled on time", {7'b0, nvm_en}, 8'h01);
        rd(0, 0, v); chk("R5 status en", v, 8'h02);
        // R7 / R10 write with bit1 high, reserved bits high
        wr(0, 8'hFE);
        rd(0, 0, v); chk("R10 R7 keep en", v, 8'h02);
        wr(0, 8'h00);
        chk("R7 cleared", {7'b0, nvm_en}, 8'h00);
        rd(0, 0, v); chk("R7 status", v, 8'h00);
        // R9 clear on the same edge as the delayed set
        key(GOOD);
        repeat (DLY - 2) @(negedge clk);
        wr(0, 8'h00);
        repeat (DLY + 3) @(negedge clk);
        chk("R9 coincident clear", {7'b0, nvm_en}, 8'h00);
        // R9 clear while pending
        key(GOOD);
        wr(0, 8'h00);
        repeat (DLY + 3) @(negedge clk);
        chk("R9 pending cancelled", {7'b0, nvm_en}, 8'h00);
        rd(0, 0, v); chk("R9 status", v, 8'h00);
        // R4 key again after a cancel
        key(GOOD);
        repeat (DLY + 1) @(negedge clk);
        chk("R4 re-enable", {7'b0, nvm_en}, 8'h01);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule